// File: doc/BRIEF.md
# Receive Link Alarm and Interrupt Register

This block holds the alarm and interrupt state that a processor sees for one receive port of a serial link disassembler. It watches three live loss-of-lock indicators: descrambler, container delineation and frame delineation. It also watches the received link trace label byte. From these it latches sticky alarm bits for a label change, a label mismatch against a processor-programmed expected label, and a change of status on any lock transition. A message-buffer-full flag lives in the same alarm register. Unlike the other alarm bits, software can write it.

The processor reaches the block over a simple 8-bit address, 8-bit data register bus. Reading the alarm register returns its contents and clears the sticky bits. If an alarm event arrives in the same cycle as that read, the event wins, so nothing is lost. An enable register with the same bit layout gates the alarm bits onto one registered interrupt line.

Top module: `rx_link_alarm`

## Requirements
- R1: After a synchronous reset, the expected label, the alarm register, the enable register, `bus_rdata` and `irq` are all zero.
- R2: Offset 0x61 holds the 8-bit expected label. It is written when `bus_wr` is high and read back when `bus_rd` is high.
- R3: Alarm bit 5 (mismatch) is set at every clock edge where `rx_label` differs from the expected label. It stays set until a read of 0x62 in a cycle where the two are equal.
- R4: Alarm bit 6 (label change) is set at an edge where `rx_label` differs from its value in the previous cycle. The label history resets to 0x00.
- R5: Alarm bit 4 (change of status) is set at an edge where any bit of `lock_loss` differs from its value in the previous cycle. This applies to a gain of lock as well as a loss. The history resets to 000.
- R6: Alarm bits 3, 2 and 1 are set while `lock_loss[2]` (descrambler), `lock_loss[1]` (container) or `lock_loss[0]` (frame) respectively is 1, where 1 means out of lock. After the input returns to 0, a read of 0x62 clears the bit.
- R7: A read of offset 0x62 returns the alarm register and clears bits 6 to 1. Bit 0 is not cleared by the read, and bit 7 always reads 0. `bus_rdata` holds the read value in the cycle after `bus_rd` and is 0x00 after a cycle without a read or after a read of an unused offset.
- R8: Alarm bit 0 (message buffer full) is set by a one-cycle `msg_rcvd` pulse. A write to 0x62 loads bit 0 from `bus_wdata[0]` and ignores `bus_wdata[7:1]`. If `msg_rcvd` arrives in the same cycle as a write of 0, bit 0 ends set.
- R9: Offset 0x63 is the interrupt enable register, using the alarm bit positions. Bits 6 to 0 can be written, and bit 7 always reads 0.
- R10: `irq` is high in the cycle after a cycle in which some alarm bit and its enable bit are both 1, and low otherwise.
- R11: If a set event for a bit among 6 to 1 occurs in the same cycle as a clearing read of 0x62, that bit remains set after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_loss | input | 3 | Live loss-of-lock: [2] descrambler, [1] container, [0] frame; 1 = out of lock |
| rx_label | input | 8 | Stored received link trace label |
| msg_rcvd | input | 1 | One-cycle pulse: a complete message has been buffered |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clears alarm bits 6..1 on offset 0x62 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check the following: a mismatch or a held loss-of-lock input always leaves its alarm bit set one edge later, and any lock transition sets the change-of-status bit. They also check that bit 0 moves only on a message pulse or a bus write, and that `irq` stays low while the enable register is zero. Some behaviours only the bench's scenarios can show. These are the read returning a value while clearing it, the set-wins-over-clear race on a read, the ignored upper write bits, and the one-cycle latency from an enabled alarm to the interrupt. The bench shows them through explicit read sequences and through a reference model compared on every clock.

// File: rtl/rla_pkg.sv
package rla_pkg;
  localparam int ALM_W   = 8;
  localparam int BIT_MSG = 0;
  localparam int BIT_FRM = 1;
  localparam int BIT_CNT = 2;
  localparam int BIT_DSC = 3;
  localparam int BIT_COS = 4;
  localparam int BIT_MIS = 5;
  localparam int BIT_LBC = 6;
  localparam int BIT_RSV = 7;
  localparam int N_LOCK  = 3;

  typedef logic [ALM_W-1:0] alarm_t;

  // bits cleared by a read of the alarm register
  localparam alarm_t COR_MASK = alarm_t'(8'b0111_1110);
  // bits software may load by a write
  localparam alarm_t WR_MASK  = alarm_t'(8'b0000_0001);
  // bits that always read zero
  localparam alarm_t RSV_MASK = alarm_t'(8'b1000_0000);
endpackage

// File: rtl/rla_edge_det.sv
module rla_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic         changed
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= d;
  end

  assign changed = (d != prev_q);
endmodule

// File: rtl/rla_sticky.sv
module rla_sticky #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] wr_sel,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] q
);
  // priority per bit: event set > software write > clear-on-read
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)            bit_q <= 1'b0;
      else if (set[i])    bit_q <= 1'b1;
      else if (wr_sel[i]) bit_q <= wr_val[i];
      else if (clr[i])    bit_q <= 1'b0;
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/rla_regs.sv
module rla_regs #(
  parameter int         AW      = 8,
  parameter int         DW      = 8,
  parameter logic [7:0] OFF_EXP = 8'h61,
  parameter logic [7:0] OFF_ALM = 8'h62,
  parameter logic [7:0] OFF_IEN = 8'h63
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] alarm_q,
  output logic [DW-1:0] exp_q,
  output logic [DW-1:0] ien_q,
  output logic          alm_rd,
  output logic          alm_wr,
  output logic [DW-1:0] rdata
);
  import rla_pkg::*;

  localparam logic [AW-1:0] A_EXP = AW'(OFF_EXP);
  localparam logic [AW-1:0] A_ALM = AW'(OFF_ALM);
  localparam logic [AW-1:0] A_IEN = AW'(OFF_IEN);
  localparam logic [DW-1:0] KEEP  = ~DW'(RSV_MASK);

  logic hit_exp, hit_alm, hit_ien;
  logic [DW-1:0] rd_mux;

  assign hit_exp = (addr == A_EXP);
  assign hit_alm = (addr == A_ALM);
  assign hit_ien = (addr == A_IEN);
  assign alm_rd  = rd & hit_alm;
  assign alm_wr  = wr & hit_alm;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q <= '0;
      ien_q <= '0;
    end else if (wr) begin
      if (hit_exp) exp_q <= wdata;
      if (hit_ien) ien_q <= wdata & KEEP;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_exp)      rd_mux = exp_q;
    else if (hit_alm) rd_mux = alarm_q & KEEP;
    else if (hit_ien) rd_mux = ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
    else         rdata <= '0;
  end
endmodule

// File: rtl/rx_link_alarm.sv
module rx_link_alarm #(
  parameter int         ADDR_W  = 8,
  parameter int         DATA_W  = 8,
  parameter int         N_LOSS  = 3,
  parameter logic [7:0] OFF_EXP = 8'h61,
  parameter logic [7:0] OFF_ALM = 8'h62,
  parameter logic [7:0] OFF_IEN = 8'h63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_LOSS-1:0] lock_loss,
  input  logic [DATA_W-1:0] rx_label,
  input  logic              msg_rcvd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import rla_pkg::*;

  alarm_t alarm_q, set_v, clr_v, wsel_v;
  logic [DATA_W-1:0] exp_q, ien_q;
  logic lbl_chg, loss_chg, alm_rd, alm_wr;

  rla_edge_det #(.W(DATA_W)) u_lbl_hist (
    .clk(clk), .rst(rst), .d(rx_label), .changed(lbl_chg)
  );

  rla_edge_det #(.W(N_LOSS)) u_loss_hist (
    .clk(clk), .rst(rst), .d(lock_loss), .changed(loss_chg)
  );

  always_comb begin
    set_v                           = '0;
    set_v[BIT_MSG]                  = msg_rcvd;
    set_v[BIT_DSC:BIT_FRM]          = lock_loss;
    set_v[BIT_COS]                  = loss_chg;
    set_v[BIT_MIS]                  = (rx_label != exp_q);
    set_v[BIT_LBC]                  = lbl_chg;
    clr_v                           = alm_rd ? COR_MASK : '0;
    wsel_v                          = alm_wr ? WR_MASK  : '0;
  end

  rla_sticky #(.N(ALM_W)) u_alarms (
    .clk(clk), .rst(rst), .set(set_v), .clr(clr_v),
    .wr_sel(wsel_v), .wr_val(bus_wdata), .q(alarm_q)
  );

  rla_regs #(
    .AW(ADDR_W), .DW(DATA_W),
    .OFF_EXP(OFF_EXP), .OFF_ALM(OFF_ALM), .OFF_IEN(OFF_IEN)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .alarm_q(alarm_q), .exp_q(exp_q), .ien_q(ien_q),
    .alm_rd(alm_rd), .alm_wr(alm_wr), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(alarm_q & ien_q);
  end
endmodule

// File: rtl/rla_checker.sv
module rla_checker #(
  parameter int         ADDR_W  = 8,
  parameter int         DATA_W  = 8,
  parameter int         N_LOSS  = 3,
  parameter logic [7:0] OFF_ALM = 8'h62
) (
  input logic              clk,
  input logic              rst,
  input logic [N_LOSS-1:0] lock_loss,
  input logic [DATA_W-1:0] rx_label,
  input logic              msg_rcvd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] exp_q,
  input logic [DATA_W-1:0] ien_q,
  input logic [DATA_W-1:0] alarm_q,
  input logic              irq
);
  AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (rst)
    (rx_label != exp_q) |=> alarm_q[5]); // R3

  AST_COS_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (lock_loss != $past(lock_loss))) |=> alarm_q[4]); // R5

  AST_LOSS_HELD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((alarm_q[3:1] & $past(lock_loss)) == $past(lock_loss))); // R6

  AST_MSG_BIT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!msg_rcvd && !(bus_wr && bus_addr == ADDR_W'(OFF_ALM))) |=> $stable(alarm_q[0])); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq); // R10
endmodule

bind rx_link_alarm rla_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_LOSS(N_LOSS), .OFF_ALM(OFF_ALM)
) u_chk (
  .clk(clk), .rst(rst), .lock_loss(lock_loss), .rx_label(rx_label),
  .msg_rcvd(msg_rcvd), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .exp_q(exp_q), .ien_q(ien_q), .alarm_q(alarm_q), .irq(irq)
);

// File: tb/sim_rx_link_alarm.sv
module sim_rx_link_alarm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] lock_loss = '0;
  logic [7:0] rx_label = '0;
  logic       msg_rcvd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_link_alarm u0 (
    .clk(clk), .rst(rst), .lock_loss(lock_loss), .rx_label(rx_label),
    .msg_rcvd(msg_rcvd), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  int m_alarm, m_en, m_exp, m_rdata, m_irq, m_plbl, m_ploss;
  always @(posedge clk) begin
    int nset, na, nrd;
    if (rst) begin
      m_alarm = 0; m_en = 0; m_exp = 0; m_rdata = 0; m_irq = 0; m_plbl = 0; m_ploss = 0;
    end else begin
      nset = 0;
      if (int'(rx_label) != m_plbl) nset += 64;
      if (int'(rx_label) != m_exp)  nset += 32;
      if (int'(lock_loss) != m_ploss) nset += 16;
      nset += int'(lock_loss) * 2;
      if (msg_rcvd) nset += 1;
      nrd = 0;
      if (bus_rd) begin
        if (bus_addr == 8'h61)      nrd = m_exp;
        else if (bus_addr == 8'h62) nrd = m_alarm;
        else if (bus_addr == 8'h63) nrd = m_en;
      end
      m_irq = ((m_alarm & m_en) != 0) ? 1 : 0;
      na = m_alarm;
      if (bus_rd && bus_addr == 8'h62) na = na % 2;
      if (bus_wr && bus_addr == 8'h62) na = (na / 2) * 2 + int'(bus_wdata[0]);
      na = (na | nset) % 128;
      if (bus_wr && bus_addr == 8'h61) m_exp = int'(bus_wdata);
      if (bus_wr && bus_addr == 8'h63) m_en = int'(bus_wdata) % 128;
      m_plbl = int'(rx_label);
      m_ploss = int'(lock_loss);
      m_alarm = na;
      m_rdata = nrd;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (int'(bus_rdata) != m_rdata || int'(irq) != m_irq) begin
        errors++;
        $display("FAIL MODEL rdata/irq: actual %h/%0d expected %h/%0d",
                 bus_rdata, irq, m_rdata[7:0], m_irq);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    rst = 1'b0;
    idle(1);
    rd(8'h62, d); chk("R1 alarm after reset", d, 8'h00);
    rd(8'h61, d); chk("R1 expected after reset", d, 8'h00);
    rd(8'h63, d); chk("R1 enable after reset", d, 8'h00);

    wr(8'h61, 8'hA5);
    rd(8'h61, d); chk("R2 expected readback", d, 8'hA5);
    rd(8'h62, d); chk("R3 mismatch set", d, 8'h20);
    rx_label = 8'hA5;
    idle(2);
    rd(8'h62, d); chk("R4 label change plus sticky mismatch (R11)", d, 8'h60);
    rd(8'h62, d); chk("R3 mismatch cleared once equal", d, 8'h00);

    lock_loss = 3'b001;
    idle(2);
    rd(8'h62, d); chk("R5 frame loss sets cos", d, 8'h12);
    rd(8'h62, d); chk("R11 held loss survives read", d, 8'h02);
    lock_loss = 3'b000;
    idle(1);
    rd(8'h62, d); chk("R5 regain of lock sets cos", d, 8'h12);
    rd(8'h62, d); chk("R6 loss bit cleared after lock", d, 8'h00);
    lock_loss = 3'b100;
    idle(1);
    lock_loss = 3'b000;
    idle(1);
    rd(8'h62, d); chk("R6 descrambler loss at bit 3", d, 8'h18);
    rd(8'h62, d); chk("R7 read clears", d, 8'h00);
    rd(8'h10, d); chk("R7 unused offset reads zero", d, 8'h00);

    wr(8'h62, 8'hFE);
    rd(8'h62, d); chk("R8 upper write bits ignored", d, 8'h00);
    msg_rcvd = 1'b1; idle(1); msg_rcvd = 1'b0;
    rd(8'h62, d); chk("R8 message pulse sets bit0", d, 8'h01);
    rd(8'h62, d); chk("R7 bit0 not cleared by read", d, 8'h01);
    wr(8'h62, 8'h00);
    rd(8'h62, d); chk("R8 write clears bit0", d, 8'h00);
    msg_rcvd = 1'b1;
    wr(8'h62, 8'h00);
    msg_rcvd = 1'b0;
    rd(8'h62, d); chk("R8 pulse beats write of 0", d, 8'h01);
    wr(8'h62, 8'h00);

    wr(8'h63, 8'hFF);
    rd(8'h63, d); chk("R9 enable bit7 reads 0", d, 8'h7F);
    idle(1);
    chk("R10 irq low with no alarm", {7'd0, irq}, 8'h00);
    msg_rcvd = 1'b1;
    @(negedge clk);
    msg_rcvd = 1'b0;
    chk("R10 irq one cycle later, not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R10 irq asserted", {7'd0, irq}, 8'h01);
    wr(8'h63, 8'h00);
    idle(2);
    chk("R10 irq drops when disabled", {7'd0, irq}, 8'h00);
    wr(8'h62, 8'h00);
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule